// File: doc/BRIEF.md
# Programmable multi-mode clock-enable divider

This block runs entirely on one master clock. From it, the block derives four clock-enable streams: a processor enable, an emulator enable at twice the processor rate, a compute-engine enable and a sampling/filter enable. Each enable is a one-cycle pulse at the master clock rate, so the logic that uses it stays on the master clock and no gated clock is made.

The stream rates are set by a few inputs:
- A 3-bit divider select picks a power-of-two processor ratio.
- Two mode bits pick one of three rate families. The normal family divides the master clock by 8 to get the base rate. The alternate family divides by 6, which is one third faster. The fast-engine family keeps the normal base rate and lets the compute engine run at double rate.
- A sleep input forces the mode bits low.
- An emulator-off input silences the emulator stream.
- A brownout input thins every stream to 7/8 of its nominal rate.

The mode and divider select are sampled only at the end of a processor period. A change therefore never cuts a period short.

Top module: `mcd_clkgen`

## Requirements
- R1: With effective divider d, the processor enable pulses once every B·2^d master cycles. B is the base ratio: 8 in normal and fast-engine modes, 6 in alternate mode.
- R2: A divider select of 7 behaves exactly as 6.
- R3: The emulator enable pulses every B·2^(d-1) master cycles, which is twice the processor rate. While emu_off is 1 it stays at 0.
- R4: During reset all enables are 0. Reset also selects normal mode with d=0, whatever the inputs are. After reset is released, the first processor pulse is visible in the cycle after the 8th rising edge.
- R5: The mode bits {fast_mode, alt_mode} decode as follows: 2'b10 is fast-engine mode, 2'b01 is alternate mode, and 2'b00 and 2'b11 are normal mode. In fast-engine mode with eng_hi_sel=1, the engine enable pulses every 4 master cycles. In every other case it pulses every B cycles.
- R6: The sampling/filter enable pulses every B cycles. It pulses every 6 cycles in alternate mode and every 8 cycles otherwise, whatever eng_hi_sel is. Every processor pulse coincides with a sampling pulse.
- R7: While sleep is 1, both mode bits are treated as 0, which gives normal mode.
- R8: While brownout is 1, each enable stream drops exactly one pulse out of every eight consecutive nominal pulses.
- R9: Divider and mode changes take effect only after the current processor period ends. The interval that was running when the change arrived keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Processor divider select (7 clamped to 6) |
| fast_mode | input | 1 | Mode bit selecting the fast-engine family |
| alt_mode | input | 1 | Mode bit selecting the alternate (6-cycle) family |
| eng_hi_sel | input | 1 | Engine double-rate select, used in fast-engine mode |
| emu_off | input | 1 | Suppresses the emulator enable |
| sleep | input | 1 | Forces both mode bits to 0 |
| brownout | input | 1 | Thins all enables to 7/8 rate |
| proc_ce | output | 1 | Processor clock enable |
| emu_ce | output | 1 | Emulator clock enable |
| eng_ce | output | 1 | Compute-engine clock enable |
| smp_ce | output | 1 | Sampling/filter clock enable |

## Verification
The bench covers every divider select in each of the five mode/select combinations and measures the minimum and maximum pulse spacing of every stream.

- A design that failed to clamp a select of 7 would show a 1024- or 768-cycle processor interval.
- A design that decoded 2'b11 as a live mode would show a wrong engine or sampling rate.
- A design that applied a new divider at once would produce a short interval when the select drops from 3 to 0 mid-period.
- Pulse counts over windows of eight periods under brownout reveal thinning that drops the wrong number of pulses.
- Counting cycles to the first pulse after reset, with the select held at 5, reveals a wrong reset default.

// File: rtl/mcd_clkgen_pkg.sv
package mcd_clkgen_pkg;

  typedef enum logic [1:0] {
    MD_NORM = 2'd0,
    MD_FAST = 2'd1,
    MD_ALT  = 2'd2
  } mode_e;

  // Mode pair decode; illegal 2'b11 falls back to normal.
  function automatic mode_e decode_mode(input logic fast_bit, input logic alt_bit);
    case ({fast_bit, alt_bit})
      2'b10:   return MD_FAST;
      2'b01:   return MD_ALT;
      default: return MD_NORM;
    endcase
  endfunction

endpackage

// File: rtl/mcd_cfg_latch.sv
module mcd_cfg_latch
  import mcd_clkgen_pkg::*;
#(
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tc,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             fast_mode,
  input  logic             alt_mode,
  input  logic             eng_hi_sel,
  input  logic             sleep,
  output mode_e            cur_mode,
  output logic [DIV_W-1:0] cur_div,
  output logic             cur_eng_hi
);

  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] div_clamped;
  mode_e            mode_next;

  always_comb begin
    div_clamped = (div_sel > DIV_LIM) ? DIV_LIM : div_sel;
    mode_next   = decode_mode(fast_mode & ~sleep, alt_mode & ~sleep);
  end

  // New settings are accepted only at the processor terminal count.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode   <= MD_NORM;
      cur_div    <= '0;
      cur_eng_hi <= 1'b0;
    end else if (tc) begin
      cur_mode   <= mode_next;
      cur_div    <= div_clamped;
      cur_eng_hi <= eng_hi_sel;
    end
  end

  a_r2_div_clamped: assert property (@(posedge clk) disable iff (rst)
    (tc && div_sel == '1) |=> (cur_div == DIV_LIM));

  a_r7_sleep_normal: assert property (@(posedge clk) disable iff (rst)
    (tc && sleep) |=> (cur_mode == MD_NORM));

  a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
    !tc |=> ($stable(cur_div) && $stable(cur_mode) && $stable(cur_eng_hi)));

endmodule

// File: rtl/mcd_phase_counter.sv
module mcd_phase_counter
  import mcd_clkgen_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int NORM_DIV = 8,
  parameter int ALT_DIV  = 6,
  parameter int CNT_W    = 10,
  parameter int SUB_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            cur_mode,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             cur_eng_hi,
  output logic             tc,
  output logic             raw_emu,
  output logic             raw_eng,
  output logic             raw_smp
);

  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] base;
  logic [CNT_W-1:0] period;
  logic             sub_tc;

  always_comb begin
    base    = (cur_mode == MD_ALT) ? SUB_W'(ALT_DIV) : SUB_W'(NORM_DIV);
    period  = CNT_W'(base) << cur_div;
    tc      = (cnt == period - 1'b1);
    sub_tc  = (sub == base - 1'b1);
    raw_emu = tc || (cnt == (period >> 1) - 1'b1);
    raw_smp = sub_tc;
    if (cur_mode == MD_FAST && cur_eng_hi)
      raw_eng = sub_tc || (sub == (base >> 1) - 1'b1);
    else
      raw_eng = sub_tc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sub <= '0;
    end else begin
      cnt <= tc ? '0 : cnt + 1'b1;
      sub <= (tc || sub_tc) ? '0 : sub + 1'b1;
    end
  end

  a_r1_tc_wrap: assert property (@(posedge clk) disable iff (rst)
    tc |=> (cnt == '0));

  a_r6_tc_on_sub_edge: assert property (@(posedge clk) disable iff (rst)
    tc |-> sub_tc);

endmodule

// File: rtl/mcd_rate_thin.sv
module mcd_rate_thin #(
  parameter int LANES  = 4,
  parameter int DROP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brownout,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] ce
);

  localparam logic [DROP_W-1:0] LAST = '1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DROP_W-1:0] seen;
    logic              drop;

    assign drop = brownout && (seen == LAST);

    always_ff @(posedge clk) begin
      if (rst) begin
        seen  <= '0;
        ce[g] <= 1'b0;
      end else begin
        ce[g] <= raw[g] && !drop;
        if (!brownout)   seen <= '0;
        else if (raw[g]) seen <= seen + 1'b1;
      end
    end

    a_r8_drop_eighth: assert property (@(posedge clk) disable iff (rst)
      (brownout && raw[g] && seen == LAST) |=> !ce[g]);

    a_r8_pass_nominal: assert property (@(posedge clk) disable iff (rst)
      (!brownout && raw[g]) |=> ce[g]);
  end

endmodule

// File: rtl/mcd_clkgen.sv
module mcd_clkgen
  import mcd_clkgen_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int DIV_MAX  = 6,
  parameter int NORM_DIV = 8,
  parameter int ALT_DIV  = 6,
  parameter int DROP_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             fast_mode,
  input  logic             alt_mode,
  input  logic             eng_hi_sel,
  input  logic             emu_off,
  input  logic             sleep,
  input  logic             brownout,
  output logic             proc_ce,
  output logic             emu_ce,
  output logic             eng_ce,
  output logic             smp_ce
);

  localparam int CNT_W = $clog2((NORM_DIV << DIV_MAX) + 1);
  localparam int SUB_W = $clog2(NORM_DIV + 1);
  localparam int LANES = 4;

  mode_e            cur_mode;
  logic [DIV_W-1:0] cur_div;
  logic             cur_eng_hi;
  logic             tc, raw_emu, raw_eng, raw_smp;
  logic [LANES-1:0] raw_vec, ce_vec;

  mcd_cfg_latch #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_cfg (
    .clk(clk), .rst(rst), .tc(tc), .div_sel(div_sel),
    .fast_mode(fast_mode), .alt_mode(alt_mode), .eng_hi_sel(eng_hi_sel),
    .sleep(sleep), .cur_mode(cur_mode), .cur_div(cur_div),
    .cur_eng_hi(cur_eng_hi)
  );

  mcd_phase_counter #(
    .DIV_W(DIV_W), .NORM_DIV(NORM_DIV), .ALT_DIV(ALT_DIV),
    .CNT_W(CNT_W), .SUB_W(SUB_W)
  ) u_phase (
    .clk(clk), .rst(rst), .cur_mode(cur_mode), .cur_div(cur_div),
    .cur_eng_hi(cur_eng_hi), .tc(tc), .raw_emu(raw_emu),
    .raw_eng(raw_eng), .raw_smp(raw_smp)
  );

  assign raw_vec = {raw_smp, raw_eng, raw_emu && !emu_off, tc};

  mcd_rate_thin #(.LANES(LANES), .DROP_W(DROP_W)) u_thin (
    .clk(clk), .rst(rst), .brownout(brownout), .raw(raw_vec), .ce(ce_vec)
  );

  assign proc_ce = ce_vec[0];
  assign emu_ce  = ce_vec[1];
  assign eng_ce  = ce_vec[2];
  assign smp_ce  = ce_vec[3];

  a_r3_emu_silent: assert property (@(posedge clk) disable iff (rst)
    emu_off |=> !emu_ce);

  a_r6_proc_with_smp: assert property (@(posedge clk) disable iff (rst)
    (proc_ce && !$past(brownout)) |-> smp_ce);

  a_r4_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> !(proc_ce || emu_ce || eng_ce || smp_ce));

endmodule

// File: tb/mcd_clkgen_bench.sv
module mcd_clkgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic fast_mode = 0, alt_mode = 0, eng_hi_sel = 0, emu_off = 0, sleep = 0, brownout = 0;
  logic proc_ce, emu_ce, eng_ce, smp_ce;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int pc[4], pmin[4], pmax[4], plast[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_clkgen u_mcd_clkgen (
    .clk(clk), .rst(rst), .div_sel(div_sel), .fast_mode(fast_mode),
    .alt_mode(alt_mode), .eng_hi_sel(eng_hi_sel), .emu_off(emu_off),
    .sleep(sleep), .brownout(brownout), .proc_ce(proc_ce),
    .emu_ce(emu_ce), .eng_ce(eng_ce), .smp_ce(smp_ce)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int w);
    logic [3:0] v;
    for (int k = 0; k < 4; k++) begin
      pc[k] = 0; pmin[k] = 1 << 30; pmax[k] = 0; plast[k] = -1;
    end
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      v = {smp_ce, eng_ce, emu_ce, proc_ce};
      for (int k = 0; k < 4; k++) if (v[k]) begin
        if (plast[k] >= 0) begin
          if (i - plast[k] < pmin[k]) pmin[k] = i - plast[k];
          if (i - plast[k] > pmax[k]) pmax[k] = i - plast[k];
        end
        plast[k] = i;
        pc[k]++;
      end
    end
  endtask

  task automatic check_period(input int lane, input int exp, input string req,
                              input string what);
    if (exp == 0) check(pc[lane] == 0, req, {what, " silent count"}, pc[lane], 0);
    else begin
      check(pc[lane] >= 2 && pmin[lane] == exp, req, {what, " min gap"}, pmin[lane], exp);
      check(pmax[lane] == exp, req, {what, " max gap"}, pmax[lane], exp);
    end
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int prev_p, p, dd, base, eng, k;
    logic [3:0] seen;
    // R4: reset state, with a nonzero select that reset must override
    div_sel = 3'd5;
    repeat (4) @(negedge clk);
    seen = {smp_ce, eng_ce, emu_ce, proc_ce};
    check(seen == 4'b0, "R4", "enables in reset", int'(seen), 0);
    rst = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!proc_ce && k < 100);
    check(k == 8, "R4", "first proc pulse edge", k, 8);
    prev_p = 256;

    // R1 R2 R3 R5 R6: sweep all selects over five mode combinations
    for (int m = 0; m < 5; m++) begin
      for (int d = 0; d < 8; d++) begin
        case (m)
          0: {fast_mode, alt_mode, eng_hi_sel} = 3'b000;
          1: {fast_mode, alt_mode, eng_hi_sel} = 3'b100;
          2: {fast_mode, alt_mode, eng_hi_sel} = 3'b101;
          3: {fast_mode, alt_mode, eng_hi_sel} = 3'b010;
          default: {fast_mode, alt_mode, eng_hi_sel} = 3'b111;
        endcase
        div_sel = 3'(d);
        emu_off = (d % 3) == 2;
        dd   = (d > 6) ? 6 : d;
        base = (m == 3) ? 6 : 8;
        eng  = (m == 2) ? 4 : base;
        p    = base << dd;
        repeat (2 * (prev_p + p)) @(negedge clk);
        measure(3 * p + 2);
        check_period(0, p, (d == 7) ? "R2" : "R1", "proc");
        check_period(1, emu_off ? 0 : p / 2, "R3", "emu");
        check_period(2, eng, "R5", "eng");
        check_period(3, base, "R6", "smp");
        prev_p = p;
      end
    end

    // R7: sleep forces normal mode
    sleep = 1'b1;
    emu_off = 1'b0;
    for (int m = 0; m < 2; m++) begin
      {fast_mode, alt_mode, eng_hi_sel} = (m == 0) ? 3'b010 : 3'b101;
      div_sel = 3'd2;
      repeat (2 * (prev_p + 32)) @(negedge clk);
      measure(3 * 32 + 2);
      check_period(0, 32, "R7", "proc in sleep");
      check_period(2, 8, "R7", "eng in sleep");
      check_period(3, 8, "R7", "smp in sleep");
      prev_p = 32;
    end
    sleep = 1'b0;

    // R9: mid-period divider change keeps the running interval
    {fast_mode, alt_mode, eng_hi_sel} = 3'b000;
    div_sel = 3'd3;
    repeat (2 * (32 + 64)) @(negedge clk);
    do @(negedge clk); while (!proc_ce);
    repeat (5) @(negedge clk);
    div_sel = 3'd0;
    k = 5;
    do begin @(negedge clk); k++; end while (!proc_ce && k < 200);
    check(k == 64, "R9", "interval spanning change", k, 64);
    k = 0;
    do begin @(negedge clk); k++; end while (!proc_ce && k < 200);
    check(k == 8, "R9", "first interval after change", k, 8);

    // R8: brownout thinning, fast-engine double rate, d=1
    {fast_mode, alt_mode, eng_hi_sel} = 3'b101;
    div_sel = 3'd1;
    repeat (64) @(negedge clk);
    brownout = 1'b1;
    repeat (3) @(negedge clk);
    measure(8 * 16);
    check(pc[0] == 7, "R8", "proc kept of 8", pc[0], 7);
    check(pc[1] == 14, "R8", "emu kept of 16", pc[1], 14);
    check(pc[2] == 28, "R8", "eng kept of 32", pc[2], 28);
    check(pc[3] == 14, "R8", "smp kept of 16", pc[3], 14);
    // R8 in alternate mode, d=0
    {fast_mode, alt_mode, eng_hi_sel} = 3'b010;
    div_sel = 3'd0;
    repeat (64) @(negedge clk);
    measure(8 * 6);
    check(pc[0] == 7, "R8", "alt proc kept of 8", pc[0], 7);
    check(pc[1] == 14, "R8", "alt emu kept of 16", pc[1], 14);
    check(pc[3] == 7, "R8", "alt smp kept of 8", pc[3], 7);
    brownout = 1'b0;
    repeat (12) @(negedge clk);
    measure(3 * 6 + 2);
    check_period(0, 6, "R8", "proc after brownout");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule